// File: doc/BRIEF.md
# UART Interrupt Aggregation Controller

This block collects eleven interrupt causes of a UART into a latched raw status word. The receive and transmit datapaths, the line-error logic and the modem-status logic each signal an event with a one-cycle pulse on `src_set`. Software owns an enable mask. The raw word ANDed with that mask forms the masked status. One combined interrupt line is driven from the masked status, together with five group lines: receive, transmit, receive timeout, modem status and line errors.

Software reaches the block through a small register port. Address 0 holds the enable mask and can be read and written. Address 1 reads the raw status. Address 2 reads the masked status. Address 3 is a write-one-to-clear port for the raw bits. The transmit path pulses bit 5 each time it accepts a byte from its data register. All outputs come from flip-flops. A change to the mask or the raw word shows on the interrupt lines at the same clock edge that stores the change.

Top module: `uart_irq_agg`

## Requirements
- R1: While `rst_n` is low, and after reset, the raw status, the enable mask, every interrupt output and `rd_data` are zero.
- R2: A 1 on bit i of `src_set` in a cycle sets raw bit i at that clock edge. The bit stays set until it is cleared. Bit layout: 10 overrun, 9 break, 8 parity, 7 framing, 6 receive timeout, 5 transmit, 4 receive, 3 DSR, 2 DCD, 1 CTS, 0 ring.
- R3: A write to address 3 clears every raw bit that is 1 in `wr_data` and leaves the other raw bits unchanged.
- R4: When a set pulse and a clear of the same bit fall in the same cycle, the bit ends set.
- R5: `rd_data` returns, one clock after `rd_addr` is presented, the enable mask (address 0), the raw status (address 1) or raw AND mask (address 2).
- R6: `irq_any` is high exactly when raw AND mask is nonzero.
- R7: `irq_rx` follows masked bit 4, `irq_tx` bit 5 and `irq_rto` bit 6. `irq_modem` is the OR of masked bits 0 to 3, and `irq_err` is the OR of masked bits 7 to 10.
- R8: A write to address 0 loads the enable mask, and all six outputs take the new masked value at that same edge.
- R9: Writes to addresses 1 and 2 change neither the raw status nor the mask.
- R10: Reading address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | 11 | One-cycle set pulses, one per interrupt cause |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 11 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 11 | Registered read data |
| irq_any | output | 1 | Combined interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rto | output | 1 | Receive-timeout interrupt |
| irq_modem | output | 1 | Modem-status interrupt |
| irq_err | output | 1 | Line-error interrupt |

## Verification
A hardware set pulse and a software write-one-to-clear of the same bit can land in the same cycle. A mask write can also coincide with a change in the raw word. The vector table drives a framing-error pulse and a clear of the framing bit in one cycle, and a read of the raw word afterwards must show the bit still set. Other vectors pair mask writes with pending raw bits, and in the same cycle each group line is compared with a model of raw and mask kept in the bench.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 11;
  localparam int NUM_GRP = 5;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADR_ENABLE = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_RAW    = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_MASKED = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CLEAR  = 2'd3;

  // group order: rx, tx, timeout, modem, error
  function automatic logic [NUM_SRC-1:0] grp_mask(input int g);
    case (g)
      0:       grp_mask = 11'h010;
      1:       grp_mask = 11'h020;
      2:       grp_mask = 11'h040;
      3:       grp_mask = 11'h00F;
      default: grp_mask = 11'h780;
    endcase
  endfunction

  // set has priority over clear
  function automatic logic [NUM_SRC-1:0] raw_update(
    input logic [NUM_SRC-1:0] cur,
    input logic [NUM_SRC-1:0] set,
    input logic [NUM_SRC-1:0] clr);
    raw_update = (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic               clr_en,
  input  logic [NUM_SRC-1:0] clr_bits,
  output logic [NUM_SRC-1:0] raw_q,
  output logic [NUM_SRC-1:0] raw_nx
);
  logic [NUM_SRC-1:0] clr_eff;

  assign clr_eff = clr_en ? clr_bits : '0;
  assign raw_nx  = raw_update(raw_q, src_set, clr_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_nx;
  end
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [NUM_SRC-1:0] wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [NUM_SRC-1:0] raw_q,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] mask_nx,
  output logic               clr_en,
  output logic [NUM_SRC-1:0] clr_bits,
  output logic [NUM_SRC-1:0] rd_data
);
  logic               mask_wr;
  logic [NUM_SRC-1:0] rd_sel;

  assign mask_wr  = wr_en && (wr_addr == ADR_ENABLE);
  assign clr_en   = wr_en && (wr_addr == ADR_CLEAR);
  assign clr_bits = wr_data;
  assign mask_nx  = mask_wr ? wr_data : mask_q;

  always_comb begin
    case (rd_addr)
      ADR_ENABLE: rd_sel = mask_q;
      ADR_RAW:    rd_sel = raw_q;
      ADR_MASKED: rd_sel = raw_q & mask_q;
      default:    rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      rd_data <= '0;
    end else begin
      mask_q  <= mask_nx;
      rd_data <= rd_sel;
    end
  end
endmodule

// File: rtl/uart_irq_route.sv
module uart_irq_route
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] raw_nx,
  input  logic [NUM_SRC-1:0] mask_nx,
  output logic               irq_any,
  output logic [NUM_GRP-1:0] irq_grp
);
  logic [NUM_SRC-1:0] masked_nx;
  assign masked_nx = raw_nx & mask_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_any <= 1'b0;
    else        irq_any <= |masked_nx;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_grp[g] <= 1'b0;
      else        irq_grp[g] <= |(masked_nx & grp_mask(g));
    end
  end
endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [NUM_SRC-1:0] wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [NUM_SRC-1:0] rd_data,
  output logic               irq_any,
  output logic               irq_rx,
  output logic               irq_tx,
  output logic               irq_rto,
  output logic               irq_modem,
  output logic               irq_err
);
  logic [NUM_SRC-1:0] raw_q, raw_nx, mask_q, mask_nx, clr_bits;
  logic               clr_en;
  logic [NUM_GRP-1:0] irq_grp;

  uart_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .raw_q(raw_q),
    .mask_q(mask_q), .mask_nx(mask_nx), .clr_en(clr_en),
    .clr_bits(clr_bits), .rd_data(rd_data)
  );

  uart_irq_status u_status (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .clr_en(clr_en),
    .clr_bits(clr_bits), .raw_q(raw_q), .raw_nx(raw_nx)
  );

  uart_irq_route u_route (
    .clk(clk), .rst_n(rst_n), .raw_nx(raw_nx), .mask_nx(mask_nx),
    .irq_any(irq_any), .irq_grp(irq_grp)
  );

  assign irq_rx    = irq_grp[0];
  assign irq_tx    = irq_grp[1];
  assign irq_rto   = irq_grp[2];
  assign irq_modem = irq_grp[3];
  assign irq_err   = irq_grp[4];
endmodule

// File: rtl/uart_irq_agg_chk.sv
module uart_irq_agg_chk
  import uart_irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_set,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [NUM_SRC-1:0] wr_data,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [NUM_SRC-1:0] rd_data,
  input logic [NUM_SRC-1:0] raw_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               irq_any,
  input logic               irq_err,
  input logic               irq_modem
);
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (raw_q == '0 && mask_q == '0 && !irq_any));

  p_set_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set != '0) |=> ((raw_q & $past(src_set)) == $past(src_set)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_CLEAR)
      |=> ((raw_q & $past(wr_data) & ~$past(src_set)) == '0));

  p_rd_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADR_MASKED) |=> (rd_data == $past(raw_q & mask_q)));

  p_any_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (|(raw_q & mask_q)));

  p_err_grp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err == (|(raw_q[10:7] & mask_q[10:7])));

  p_modem_grp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_modem == (|(raw_q[3:0] & mask_q[3:0])));

  p_ro_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ADR_RAW || wr_addr == ADR_MASKED) && src_set == '0)
      |=> ($stable(raw_q) && $stable(mask_q)));
endmodule

bind uart_irq_agg uart_irq_agg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_set(src_set), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
  .rd_data(rd_data), .raw_q(raw_q), .mask_q(mask_q),
  .irq_any(irq_any), .irq_err(irq_err), .irq_modem(irq_modem)
);

// File: tb/test_uart_irq_agg.sv
module test_uart_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] src_set = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [10:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [10:0] rd_data;
  logic irq_any, irq_rx, irq_tx, irq_rto, irq_modem, irq_err;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  uart_irq_agg i_uart_irq_agg (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_any(irq_any), .irq_rx(irq_rx),
    .irq_tx(irq_tx), .irq_rto(irq_rto), .irq_modem(irq_modem),
    .irq_err(irq_err)
  );

  // vector: [24:14] set pulses, [13] write, [12:11] address, [10:0] data
  localparam logic [24:0] VEC [12] = '{
    {11'h010, 1'b0, 2'd0, 11'h000},  // rx pending, mask closed
    {11'h000, 1'b1, 2'd0, 11'h7FF},  // R8 open mask
    {11'h020, 1'b0, 2'd0, 11'h000},  // tx accepted
    {11'h000, 1'b1, 2'd3, 11'h010},  // R3 clear rx only
    {11'h401, 1'b0, 2'd0, 11'h000},  // overrun + ring
    {11'h000, 1'b1, 2'd0, 11'h040},  // R8 timeout only
    {11'h040, 1'b0, 2'd0, 11'h000},  // timeout event
    {11'h000, 1'b1, 2'd3, 11'h7FF},  // R3 clear all
    {11'h080, 1'b1, 2'd3, 11'h080},  // R4 set and clear together
    {11'h000, 1'b1, 2'd0, 11'h780},  // R8 errors only
    {11'h000, 1'b1, 2'd1, 11'h7FF},  // R9 write to raw address
    {11'h000, 1'b1, 2'd2, 11'h000}   // R9 write to masked address
  };

  logic [10:0] m_raw = '0;
  logic [10:0] m_en = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_irq(input logic [10:0] r, input logic [10:0] e);
    logic [10:0] m;
    m = r & e;
    return {m != 0, m[7] | m[8] | m[9] | m[10], m[0] | m[1] | m[2] | m[3],
            m[6], m[5], m[4]};
  endfunction

  function automatic logic [5:0] got_irq();
    return {irq_any, irq_err, irq_modem, irq_rto, irq_tx, irq_rx};
  endfunction

  task automatic rd(input logic [1:0] a, output logic [10:0] v);
    @(negedge clk) rd_addr = a;
    @(posedge clk);
    @(negedge clk) v = rd_data;
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [10:0] v;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {26'd0, got_irq()}, 32'd0);
    check("R1 rd_data in reset", {21'd0, rd_data}, 32'd0);
    rst_n = 1'b1;
    rd(2'd0, v); check("R1 mask after reset", {21'd0, v}, 32'd0);
    rd(2'd1, v); check("R1 raw after reset", {21'd0, v}, 32'd0);

    for (int i = 0; i < 12; i++) begin
      logic [24:0] t;
      logic [10:0] clr;
      t = VEC[i];
      @(negedge clk);
      src_set = t[24:14]; wr_en = t[13]; wr_addr = t[12:11]; wr_data = t[10:0];
      @(negedge clk);
      src_set = '0; wr_en = 1'b0;
      clr = (t[13] && t[12:11] == 2'd3) ? t[10:0] : 11'h000;
      m_raw = (m_raw & ~clr) | t[24:14];
      if (t[13] && t[12:11] == 2'd0) m_en = t[10:0];
      check($sformatf("R6/R7 irq vec %0d", i), {26'd0, got_irq()},
            {26'd0, exp_irq(m_raw, m_en)});
      rd(2'd1, v);
      check($sformatf("R2/R3/R4/R9 raw vec %0d", i), {21'd0, v}, {21'd0, m_raw});
      rd(2'd2, v);
      check($sformatf("R5 masked vec %0d", i), {21'd0, v}, {21'd0, m_raw & m_en});
    end

    rd(2'd0, v); check("R5 mask readback", {21'd0, v}, {21'd0, m_en});
    rd(2'd3, v); check("R10 clear address reads zero", {21'd0, v}, 32'd0);

    // R8: mask write lands the same edge as outputs change
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd0; wr_data = 11'h000;
    @(negedge clk); wr_en = 1'b0;
    check("R8 closing mask drops irqs", {26'd0, got_irq()}, 32'd0);

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 irq on reset", {26'd0, got_irq()}, 32'd0);
    rst_n = 1'b1;
    rd(2'd1, v); check("R1 raw cleared by reset", {21'd0, v}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule